// File: doc/BRIEF.md
# Carry-Save Summand Reduction Tree

This block adds twenty pre-aligned partial-product words in a single combinational step. It builds a tree of carry-save compressors, where each compressor is a row of full adders that turns three words into a sum word and a carry word. The tree collapses the twenty words into two. One ordinary carry-propagating addition then merges those two words into the result. The block has no storage, so the result follows the inputs within the same cycle.

Callers shift each summand to its bit weight before it enters the block. Any two's-complement sign-correction terms go into the summand words as well. All arithmetic wraps modulo 2^W, so W must hold the full product width plus guard bits. Sign-extended negative summands then add correctly.

The tree is scheduled greedily. At every level the words still present are taken three at a time, and each group feeds its own compressor. One or two words left over skip to the next level unchanged. For twenty inputs the word count per level runs 20, 14, 10, 7, 5, 4, 3 and 2, which is seven levels and eighteen compressors in total.

Top module: `wt_csa_tree`

## Requirements
- R1: `total_o` equals the sum of all `N_OPS` summand words, taken modulo 2^W.
- R2: `sum_vec_o + carry_vec_o`, taken modulo 2^W, equals the modulo-2^W sum of all summand words.
- R3: Bit 0 of `carry_vec_o` is always 0, because every carry word moves up one bit before it is used.
- R4: When every summand is zero, `sum_vec_o`, `carry_vec_o` and `total_o` are all zero.
- R5: When exactly one summand is non-zero, at any of the positions 0 to 19, `sum_vec_o` equals that summand and `carry_vec_o` is zero.
- R6: Carries out of bit W-1 are discarded. With every summand all ones, `total_o` is 2^W - 20.
- R7: The outputs are purely combinational. A new set of summands appears at `total_o` in the same clock cycle, with no latency and no state.
- R8: Sign-extended two's-complement summands with mixed signs produce the signed total, sign-extended to W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| summands_i | input | N_OPS x W | Pre-aligned summand words; element k is summand k |
| sum_vec_o | output | W | Redundant sum word left by the last compressor |
| carry_vec_o | output | W | Redundant carry word left by the last compressor, already shifted up one bit |
| total_o | output | W | Carry-propagated total of the two redundant words |

## Verification
A single non-zero word is moved through every input position. A pass-through or grouping error in the schedule would drop that word, or land it in the carry word, at that position. All-ones inputs exercise every top-bit carry. A tree that kept or misplaced the carry leaving bit W-1 would give a total other than 2^W - 20. Random and mixed-sign sets catch a wrong full-adder majority term or a carry word that was not shifted: the redundant pair or the total would then disagree with the plain sum, and a non-zero bit 0 in the carry word would expose the missing shift directly.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // word count after one level of three-to-two grouping
  function automatic int unsigned next_count(int unsigned n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // number of levels until two words remain
  function automatic int unsigned depth_of(int unsigned n);
    int unsigned c;
    int unsigned d;
    c = n;
    d = 0;
    while (c > 2) begin
      c = next_count(c);
      d++;
    end
    return d;
  endfunction

  // word count entering level lvl
  function automatic int unsigned count_at(int unsigned n, int unsigned lvl);
    int unsigned c;
    c = n;
    for (int unsigned i = 0; i < lvl; i++) c = next_count(c);
    return c;
  endfunction

  // word offset of level lvl inside the flattened net bus
  function automatic int unsigned base_of(int unsigned n, int unsigned lvl);
    int unsigned b;
    b = 0;
    for (int unsigned i = 0; i < lvl; i++) b += count_at(n, i);
    return b;
  endfunction

endpackage

// File: rtl/wt_full_adder.sv
module wt_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  logic half;
  assign half = a_i ^ b_i;
  assign s_o  = half ^ c_i;
  assign co_o = (a_i & b_i) | (c_i & half);
endmodule

// File: rtl/wt_csa_row.sv
module wt_csa_row #(
  parameter int unsigned W = 48
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-2:0] cy;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == W - 1) begin : g_top
      // carry out of the top bit would leave the word: sum only
      assign sum_o[b] = a_i[b] ^ b_i[b] ^ c_i[b];
    end else begin : g_fa
      wt_full_adder u_fa (
        .a_i  (a_i[b]),
        .b_i  (b_i[b]),
        .c_i  (c_i[b]),
        .s_o  (sum_o[b]),
        .co_o (cy[b])
      );
    end
  end

  assign carry_o = {cy, 1'b0};
endmodule

// File: rtl/wt_csa_level.sv
module wt_csa_level #(
  parameter int unsigned N_IN = 20,
  parameter int unsigned W    = 48,
  localparam int unsigned N_OUT = wt_pkg::next_count(N_IN)
) (
  input  logic [N_IN-1:0][W-1:0]  ops_i,
  output logic [N_OUT-1:0][W-1:0] ops_o
);
  localparam int unsigned GROUPS = N_IN / 3;
  localparam int unsigned LEFT   = N_IN % 3;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    wt_csa_row #(.W(W)) u_row (
      .a_i     (ops_i[3*g]),
      .b_i     (ops_i[3*g+1]),
      .c_i     (ops_i[3*g+2]),
      .sum_o   (ops_o[2*g]),
      .carry_o (ops_o[2*g+1])
    );
  end

  for (genvar j = 0; j < LEFT; j++) begin : g_pass
    assign ops_o[2*GROUPS+j] = ops_i[3*GROUPS+j];
  end
endmodule

// File: rtl/wt_csa_tree.sv
module wt_csa_tree #(
  parameter int unsigned N_OPS = 20,
  parameter int unsigned W     = 48
) (
  input  logic [N_OPS-1:0][W-1:0] summands_i,
  output logic [W-1:0]            sum_vec_o,
  output logic [W-1:0]            carry_vec_o,
  output logic [W-1:0]            total_o
);
  import wt_pkg::*;

  localparam int unsigned LEVELS    = depth_of(N_OPS);
  localparam int unsigned FINAL_OFS = base_of(N_OPS, LEVELS);
  localparam int unsigned TOTAL_OPS = FINAL_OFS + 2;

  // every level's words laid end to end, level 0 first
  logic [TOTAL_OPS*W-1:0] net;

  assign net[N_OPS*W-1:0] = summands_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int unsigned NI  = count_at(N_OPS, l);
    localparam int unsigned NO  = count_at(N_OPS, l + 1);
    localparam int unsigned IOF = base_of(N_OPS, l);
    localparam int unsigned OOF = base_of(N_OPS, l + 1);
    wt_csa_level #(.N_IN(NI), .W(W)) u_level (
      .ops_i (net[IOF*W +: NI*W]),
      .ops_o (net[OOF*W +: NO*W])
    );
  end

  assign sum_vec_o   = net[FINAL_OFS*W +: W];
  assign carry_vec_o = net[(FINAL_OFS+1)*W +: W];
  assign total_o     = sum_vec_o + carry_vec_o;
endmodule

// File: rtl/wt_csa_tree_chk.sv
module wt_csa_tree_chk #(
  parameter int unsigned N_OPS = 20,
  parameter int unsigned W     = 48
) (
  input logic [N_OPS-1:0][W-1:0] summands_i,
  input logic [W-1:0]            sum_vec_o,
  input logic [W-1:0]            carry_vec_o,
  input logic [W-1:0]            total_o
);
  logic [W-1:0] ref_total;
  logic [W-1:0] lone_word;
  int           nz_cnt;

  always_comb begin
    ref_total = '0;
    lone_word = '0;
    nz_cnt    = 0;
    for (int k = 0; k < int'(N_OPS); k++) begin
      ref_total = ref_total + summands_i[k];
      if (summands_i[k] != '0) begin
        nz_cnt    = nz_cnt + 1;
        lone_word = summands_i[k];
      end
    end
  end

  always_comb begin
    // R1
    total_sum_chk: assert (total_o == ref_total);
    // R2
    redundant_pair_chk: assert (W'(sum_vec_o + carry_vec_o) == ref_total);
    // R4
    zero_in_chk: assert (nz_cnt != 0 || (sum_vec_o == '0 && carry_vec_o == '0));
    // R5
    lone_word_chk: assert (nz_cnt != 1 || (sum_vec_o == lone_word && carry_vec_o == '0));
  end
endmodule

bind wt_csa_tree wt_csa_tree_chk #(.N_OPS(N_OPS), .W(W)) chk_i (
  .summands_i  (summands_i),
  .sum_vec_o   (sum_vec_o),
  .carry_vec_o (carry_vec_o),
  .total_o     (total_o)
);

// File: tb/wt_csa_tree_tb_top.sv
module wt_csa_tree_tb_top;
  localparam int unsigned N = 20;
  localparam int unsigned W = 48;

  typedef struct {
    logic [W-1:0] exp_total;
    logic [W-1:0] exp_sum;
    bit           exact;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0][W-1:0] summands = '0;
  logic [W-1:0] sum_vec, carry_vec, total;

  item_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wt_csa_tree #(.N_OPS(N), .W(W)) dut_i (
    .summands_i  (summands),
    .sum_vec_o   (sum_vec),
    .carry_vec_o (carry_vec),
    .total_o     (total)
  );

  function automatic logic [W-1:0] rnd_word();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[W-1:0];
  endfunction

  // driver: apply one set, push what the ports must show this cycle
  task automatic drive(input logic [N-1:0][W-1:0] v, input bit exact,
                       input logic [W-1:0] lone, input string tag);
    item_t it;
    logic [W-1:0] acc;
    acc = '0;
    for (int k = 0; k < int'(N); k++) acc = acc + v[k];
    @(posedge clk);
    summands = v;
    it.exp_total = acc;
    it.exp_sum   = lone;
    it.exact     = exact;
    it.tag       = tag;
    sb_q.push_back(it);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // monitor: sample mid-cycle, away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(total == it.exp_total, it.tag, "total (R1/R7)", total, it.exp_total);
        check(W'(sum_vec + carry_vec) == it.exp_total, it.tag, "pair sum (R2)",
              W'(sum_vec + carry_vec), it.exp_total);
        check(carry_vec[0] == 1'b0, it.tag, "carry bit0 (R3)", carry_vec, '0);
        if (it.exact) begin
          check(sum_vec == it.exp_sum, it.tag, "sum word", sum_vec, it.exp_sum);
          check(carry_vec == '0, it.tag, "carry word", carry_vec, '0);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0][W-1:0] v;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R4: reset state, all-zero inputs
    v = '0;
    drive(v, 1'b1, '0, "R4");

    // R5: lone word walked through every position
    for (int p = 0; p < int'(N); p++) begin
      logic [W-1:0] w;
      w = rnd_word() | W'(1);
      v = '0;
      v[p] = w;
      drive(v, 1'b1, w, "R5");
    end
    v = '0;
    v[N-1] = {W{1'b1}};
    drive(v, 1'b1, {W{1'b1}}, "R5");

    // R6: all ones wraps to 2^W - 20
    for (int k = 0; k < int'(N); k++) v[k] = {W{1'b1}};
    drive(v, 1'b0, '0, "R6");
    n_chk++;
    if ((~W'(0)) * W'(N) != W'(-20)) begin
      n_bad++;
      $display("FAIL R6 bench constant: got %h expected %h", (~W'(0)) * W'(N), W'(-20));
    end

    // R7: alternating patterns, each seen in its own cycle
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < int'(N); k++)
        v[k] = ((r + k) % 2 == 0) ? {(W/2){2'b10}} : {(W/2){2'b01}};
      drive(v, 1'b0, '0, "R7");
    end

    // R8: mixed-sign sign-extended words, against a signed reference
    for (int r = 0; r < 40; r++) begin
      longint s_ref;
      s_ref = 0;
      for (int k = 0; k < int'(N); k++) begin
        int sv;
        sv = int'($urandom_range(0, 2000000)) - 1000000;
        v[k] = W'(sv);
        s_ref += longint'(sv);
      end
      drive(v, 1'b0, '0, "R8");
      @(negedge clk);
      check(total == W'(s_ref), "R8", "signed total", total, W'(s_ref));
    end

    // R1: random full-width sets
    for (int r = 0; r < 300; r++) begin
      for (int k = 0; k < int'(N); k++) v[k] = rnd_word();
      drive(v, 1'b0, '0, "R1");
    end

    while (sb_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule